// File: doc/BRIEF.md
# Low-Power Regulator Mode Controller

This block chooses which supply feeds a microcontroller's core domain. It holds one control register, follows the core between run mode and deep sleep, and drives enables for two regulators: a main regulator (normal or low-current mode) and an ultra-low-power regulator. Software writes the control word through a simple write port and reads it back at any time.

A deep-sleep request moves the sequencer into deep sleep. The regulator selection there depends on two bits, with a fixed precedence. A change on the wake pin, when enabled, brings the core back to run mode and raises a wake request, which stays up until it is acknowledged. A software-reset bit returns the power-control state to its defaults and gives a one-cycle clear pulse to the real-time-clock registers.

Two further resets act in a narrow way. A core-domain reset and an external reset-pin event each clear only the low-current bit and force run mode. The ultra-low-regulator bit changes only through a register write or the main reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst`, `rd_data` is 0, `wake_req`, `rtc_clr` and `pull_dn` are 0, and the outputs select the main regulator in normal mode: `main_en`=1, `main_lowcur`=0, `ulp_en`=0, `core_pwr`=1.
- R2: Control word layout: bit 0 wake enable, bit 1 ultra-low regulator on, bit 2 main regulator off in deep sleep, bit 3 low-current run mode, bit 4 software reset; higher bits read 0. A write shows on `rd_data` after the edge that takes it. The regulator outputs follow one edge later.
- R3: In run mode, low-current=1 gives `ulp_en`=1 and `main_en`=0. Low-current=0 gives `main_en`=1 with `main_lowcur`=0 and `ulp_en`=0. The ultra-low-on and main-off bits have no effect in run mode.
- R4: `sleep_req` high at an edge in run mode, with no wake request pending, enters deep sleep. The regulator outputs take the deep-sleep selection at that same edge.
- R5: In deep sleep with ultra-low on=1: `ulp_en`=1, `main_en`=0, `core_pwr`=1. The main-off and low-current bits are ignored.
- R6: In deep sleep with ultra-low on=0: main-off=0 gives `main_en`=1, `main_lowcur`=1, `ulp_en`=0, `core_pwr`=1. Main-off=1 turns all enables off and `core_pwr`=0.
- R7: In deep sleep with wake enable=1, a `wake_pin` value that differs from the value at the previous edge sets `wake_req` and returns the outputs to the run selection at that edge. With wake enable=0 the pin is ignored.
- R8: `wake_req` stays 1 until `wake_ack` is sampled high. While it is pending, `sleep_req` is ignored.
- R9: `pull_dn` is 1 exactly when wake enable=1 and `wake_pol`=1 (active-high pin).
- R10: A `core_rst` or `pin_rst` pulse clears the low-current bit at that edge and forces run mode. The other fields keep their values.
- R11: The ultra-low-on bit changes only through a register write or `rst`.
- R12: Writing 1 to bit 4 clears all control fields and any pending wake request at that edge. Bit 4 then reads 1 for one cycle and 0 after that, and `rtc_clr` is high for that same single cycle.
- R13: Whenever `core_pwr`=1, at least one of `main_en` and `ulp_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high supply-domain reset |
| core_rst | input | 1 | Core-domain reset pulse |
| pin_rst | input | 1 | External reset-pin event pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control write value |
| rd_data | output | DATA_W | Control register read value |
| sleep_req | input | 1 | Deep-sleep request |
| wake_pin | input | 1 | Wake pin level |
| wake_pol | input | 1 | 1 when the wake pin is active high |
| wake_ack | input | 1 | Clears a pending wake request |
| wake_req | output | 1 | Pending wake request |
| pull_dn | output | 1 | Pull-down request for the wake pin |
| main_en | output | 1 | Main regulator enable |
| main_lowcur | output | 1 | Main regulator low-current mode |
| ulp_en | output | 1 | Ultra-low-power regulator enable |
| core_pwr | output | 1 | Core domain powered |
| rtc_clr | output | 1 | One-cycle clear pulse to clock registers |

## Verification
The results fall due at different edges. Control fields, `wake_req`, the run/deep state and the regulator outputs driven by `sleep_req` or a wake event all change at the edge that samples the stimulus. Regulator outputs driven by a register write change one edge later. `rtc_clr` and the read-back of bit 4 appear one edge after the software-reset write and drop at the next edge. The bench drives inputs just after a falling edge and samples at the falling edge after the rising edge where each result is due. For writes it waits one extra edge before it compares the regulator outputs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Control word bit positions
    localparam int BIT_WKEN  = 0;
    localparam int BIT_ULP   = 1;
    localparam int BIT_MOFF  = 2;
    localparam int BIT_LOWC  = 3;
    localparam int BIT_SWRST = 4;
    localparam int CTRL_BITS = 5;

    typedef enum logic {
        PM_RUN  = 1'b0,
        PM_DEEP = 1'b1
    } pm_state_e;

    typedef struct packed {
        logic lowcur;
        logic main_off;
        logic ulp_on;
        logic wk_en;
    } pm_ctrl_t;

    typedef struct packed {
        logic main_en;
        logic main_lc;
        logic ulp_en;
        logic core_pwr;
    } reg_sel_t;

    localparam reg_sel_t SEL_MAIN_NORM = '{main_en: 1'b1, main_lc: 1'b0, ulp_en: 1'b0, core_pwr: 1'b1};
    localparam reg_sel_t SEL_MAIN_LC   = '{main_en: 1'b1, main_lc: 1'b1, ulp_en: 1'b0, core_pwr: 1'b1};
    localparam reg_sel_t SEL_ULP       = '{main_en: 1'b0, main_lc: 1'b0, ulp_en: 1'b1, core_pwr: 1'b1};
    localparam reg_sel_t SEL_ALL_OFF   = '{main_en: 1'b0, main_lc: 1'b0, ulp_en: 1'b0, core_pwr: 1'b0};

    // Supply choice for a given mode and control word
    function automatic reg_sel_t pick_supply(pm_state_e st, pm_ctrl_t c);
        reg_sel_t s;
        if (st == PM_RUN) begin
            s = c.lowcur ? SEL_ULP : SEL_MAIN_NORM;
        end else if (c.ulp_on) begin
            s = SEL_ULP;
        end else if (c.main_off) begin
            s = SEL_ALL_OFF;
        end else begin
            s = SEL_MAIN_LC;
        end
        return s;
    endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_rst,
    input  logic              pin_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output pm_ctrl_t          ctrl,
    output logic              sw_hit,
    output logic              sw_pulse,
    output logic [DATA_W-1:0] rd_data
);

    logic     sw_q;
    pm_ctrl_t wr_fields;
    logic     unused_hi;

    assign sw_hit    = wr_en & wr_data[BIT_SWRST];
    assign unused_hi = ^wr_data[DATA_W-1:CTRL_BITS];

    always_comb begin
        wr_fields.wk_en    = wr_data[BIT_WKEN];
        wr_fields.ulp_on   = wr_data[BIT_ULP];
        wr_fields.main_off = wr_data[BIT_MOFF];
        wr_fields.lowcur   = wr_data[BIT_LOWC];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            sw_q <= 1'b0;
        end else begin
            sw_q <= sw_hit;
            if (sw_hit) begin
                ctrl <= '0;
            end else if (wr_en) begin
                ctrl <= wr_fields;
            end
            if (core_rst || pin_rst) begin
                ctrl.lowcur <= 1'b0;
            end
        end
    end

    assign sw_pulse = sw_q;

    always_comb begin
        rd_data            = '0;
        rd_data[BIT_WKEN]  = ctrl.wk_en;
        rd_data[BIT_ULP]   = ctrl.ulp_on;
        rd_data[BIT_MOFF]  = ctrl.main_off;
        rd_data[BIT_LOWC]  = ctrl.lowcur;
        rd_data[BIT_SWRST] = sw_q;
    end

    // R12
    swrst_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_q && !sw_hit) |=> !sw_q);

    // R12
    swrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sw_hit |=> (ctrl == '0) && sw_q);

    // R10
    lowcur_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rst || pin_rst) |=> !ctrl.lowcur);

    // R11
    ulp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl.ulp_on));

endmodule

// File: rtl/pmc_wake.sv
module pmc_wake (
    input  logic clk,
    input  logic rst,
    input  logic in_deep,
    input  logic wk_en,
    input  logic wake_pin,
    input  logic wake_ack,
    input  logic clr,
    output logic wake_evt,
    output logic wake_req
);

    logic pin_q;

    assign wake_evt = in_deep & wk_en & (wake_pin != pin_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            pin_q <= wake_pin;
            if (clr) begin
                wake_req <= 1'b0;
            end else if (wake_evt) begin
                wake_req <= 1'b1;
            end else if (wake_ack) begin
                wake_req <= 1'b0;
            end
        end
    end

    // R7
    wake_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_evt && !clr) |=> wake_req);

    // R7
    wake_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!wake_req && !wk_en) |=> !wake_req);

    // R8
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !wake_ack && !clr) |=> wake_req);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     force_run,
    input  logic     wake_evt,
    input  logic     wake_req,
    input  logic     sleep_req,
    input  pm_ctrl_t ctrl,
    output logic     in_deep,
    output reg_sel_t sel
);

    pm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (force_run || wake_evt) begin
            state_d = PM_RUN;
        end else if (state_q == PM_RUN && sleep_req && !wake_req) begin
            state_d = PM_DEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            sel     <= SEL_MAIN_NORM;
        end else begin
            state_q <= state_d;
            sel     <= pick_supply(state_d, ctrl);
        end
    end

    assign in_deep = (state_q == PM_DEEP);

    // R13
    pwr_src_chk: assert property (@(posedge clk) disable iff (rst)
        sel.core_pwr |-> (sel.main_en || sel.ulp_en));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_deep && sleep_req && !wake_req && !force_run) |=> in_deep);

    // R7
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> !in_deep);

    // R5
    deep_ulp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_deep && $past(ctrl.ulp_on)) |-> (sel.ulp_en && !sel.main_en));

    // R6
    deep_off_chk: assert property (@(posedge clk) disable iff (rst)
        (in_deep && $past(!ctrl.ulp_on && ctrl.main_off)) |-> !sel.core_pwr);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_rst,
    input  logic              pin_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sleep_req,
    input  logic              wake_pin,
    input  logic              wake_pol,
    input  logic              wake_ack,
    output logic              wake_req,
    output logic              pull_dn,
    output logic              main_en,
    output logic              main_lowcur,
    output logic              ulp_en,
    output logic              core_pwr,
    output logic              rtc_clr
);

    pm_ctrl_t ctrl;
    reg_sel_t sel;
    logic     sw_hit;
    logic     in_deep;
    logic     wake_evt;

    pmc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .core_rst (core_rst),
        .pin_rst  (pin_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .sw_hit   (sw_hit),
        .sw_pulse (rtc_clr),
        .rd_data  (rd_data)
    );

    pmc_wake u_wake (
        .clk      (clk),
        .rst      (rst),
        .in_deep  (in_deep),
        .wk_en    (ctrl.wk_en),
        .wake_pin (wake_pin),
        .wake_ack (wake_ack),
        .clr      (sw_hit),
        .wake_evt (wake_evt),
        .wake_req (wake_req)
    );

    pmc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .force_run (core_rst | pin_rst),
        .wake_evt  (wake_evt),
        .wake_req  (wake_req),
        .sleep_req (sleep_req),
        .ctrl      (ctrl),
        .in_deep   (in_deep),
        .sel       (sel)
    );

    assign pull_dn     = ctrl.wk_en & wake_pol;
    assign main_en     = sel.main_en;
    assign main_lowcur = sel.main_lc;
    assign ulp_en      = sel.ulp_en;
    assign core_pwr    = sel.core_pwr;

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              core_rst = 1'b0;
    logic              pin_rst = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              sleep_req = 1'b0;
    logic              wake_pin = 1'b0;
    logic              wake_pol = 1'b0;
    logic              wake_ack = 1'b0;
    logic              wake_req, pull_dn, main_en, main_lowcur, ulp_en, core_pwr, rtc_clr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .core_rst(core_rst), .pin_rst(pin_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sleep_req(sleep_req), .wake_pin(wake_pin), .wake_pol(wake_pol),
        .wake_ack(wake_ack), .wake_req(wake_req), .pull_dn(pull_dn),
        .main_en(main_en), .main_lowcur(main_lowcur), .ulp_en(ulp_en),
        .core_pwr(core_pwr), .rtc_clr(rtc_clr)
    );

    // {main_en, main_lowcur, ulp_en, core_pwr}
    function automatic logic [3:0] sel_now();
        return {main_en, main_lowcur, ulp_en, core_pwr};
    endfunction

    // {deep, lowcur, main_off, ulp_on, wk_en, expected sel}
    localparam logic [8:0] VECS [10] = '{
        9'b0_0000_1001,  // R3 run, main normal
        9'b0_1000_0011,  // R3 run, low-current -> ultra-low
        9'b0_1110_0011,  // R3 run, other bits ignored
        9'b0_0110_1001,  // R3 run, ulp_on/main_off ignored
        9'b1_0010_0011,  // R5 deep, ultra-low
        9'b1_0110_0011,  // R5 deep, main_off ignored
        9'b1_0000_1101,  // R6 deep, main low-current
        9'b1_0100_0000,  // R6 deep, core off
        9'b1_1000_1101,  // R6 deep, lowcur ignored
        9'b1_1100_0000   // R6 deep, off despite lowcur
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic write(logic [DATA_W-1:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic enter_sleep();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 sel", sel_now(), 4'b1001);
        chk("R1 wake_req/rtc_clr/pull_dn", {wake_req, rtc_clr, pull_dn}, 0);

        // Vector table: R3, R4, R5, R6
        foreach (VECS[i]) begin
            do_reset();
            write({4'b0, VECS[i][7:4]});
            step();
            if (VECS[i][8]) enter_sleep();
            chk(VECS[i][8] ? "R4/R5/R6 deep sel" : "R3 run sel", sel_now(), VECS[i][3:0]);
        end

        // R2 write/readback timing
        do_reset();
        wr_en = 1'b1; wr_data = 8'hEF;
        step();
        wr_en = 1'b0; wr_data = '0;
        chk("R2 readback", rd_data, 8'h0F);
        chk("R2 outputs lag write", sel_now(), 4'b1001);
        step();
        chk("R2 outputs follow", sel_now(), 4'b0011);

        // R9 pull-down
        do_reset();
        write(8'h01);
        wake_pol = 1'b1;
        #0.1;
        chk("R9 pull_dn active high", pull_dn, 1);
        wake_pol = 1'b0;
        #0.1;
        chk("R9 pull_dn active low", pull_dn, 0);
        write(8'h00);
        wake_pol = 1'b1;
        #0.1;
        chk("R9 pull_dn disabled", pull_dn, 0);
        wake_pol = 1'b0;

        // R10, R11 core_rst / pin_rst
        do_reset();
        write(8'h0F);
        core_rst = 1'b1; step(); core_rst = 1'b0;
        chk("R10 core_rst clears lowcur / R11 ulp kept", rd_data, 8'h07);
        write(8'h0F);
        pin_rst = 1'b1; step(); pin_rst = 1'b0;
        chk("R10 pin_rst clears lowcur / R11 ulp kept", rd_data, 8'h07);

        // R12 software reset
        do_reset();
        write(8'h0F);
        write(8'h1F);
        chk("R12 fields cleared, bit4 set", rd_data, 8'h10);
        chk("R12 rtc_clr high", rtc_clr, 1);
        step();
        chk("R12 bit4 self-clears", rd_data, 8'h00);
        chk("R12 rtc_clr one cycle", rtc_clr, 0);

        // R7, R8 wake with enable
        do_reset();
        write(8'h01);
        step();
        enter_sleep();
        chk("R4 deep main low-current", sel_now(), 4'b1101);
        wake_pin = 1'b1;
        step();
        chk("R7 wake_req set", wake_req, 1);
        chk("R7 back to run selection", sel_now(), 4'b1001);
        step(); step(); step();
        chk("R8 wake_req held", wake_req, 1);
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R8 sleep blocked while pending", sel_now(), 4'b1001);
        wake_ack = 1'b1;
        step();
        wake_ack = 1'b0;
        chk("R8 ack clears wake_req", wake_req, 0);

        // R12 software reset clears pending wake
        wake_pin = 1'b0;
        step();
        enter_sleep();
        wake_pin = 1'b1;
        step();
        write(8'h10);
        chk("R12 wake_req cleared", wake_req, 0);

        // R7 pin ignored when disabled, R10 core_rst exits deep
        do_reset();
        write(8'h00);
        step();
        enter_sleep();
        wake_pin = 1'b0;
        step();
        chk("R7 ignored: no wake_req", wake_req, 0);
        chk("R7 ignored: stays deep", sel_now(), 4'b1101);
        core_rst = 1'b1; step(); core_rst = 1'b0;
        chk("R10 core_rst forces run", sel_now(), 4'b1001);
        chk("R13 core powered from a regulator", core_pwr & (main_en | ulp_en), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule